// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Per-Operation Flag Control

This block is a purely combinational 8-bit arithmetic and logic unit. It takes two operands, a carry-in, the current status flags and a 5-bit operation code. It returns three things: the result, the new flag values and an update mask. The flags are half-carry (H), two's-complement overflow (V), negative (N), zero (Z) and carry (C). The mask marks the flags that the selected operation writes. A status register outside the block commits the flags that the mask selects.

The block covers these operations:
- addition and subtraction, each with and without carry;
- bitwise logic;
- one's and two's complement;
- increment and decrement;
- shifts and rotates;
- nibble exchange;
- loading all ones.

An instruction that takes an immediate operand uses the register form of the same operation, with the constant placed on operand B. A compare is a subtraction whose result the surrounding datapath discards. A compare with carry is likewise a subtract-with-carry whose result is discarded. Register-file access, instruction sequencing and the status register itself are outside the block.

Top module: `alu8_core`

## Requirements
- R1: Codes 0 (add) and 1 (add with carry-in) give A+B, or A+B+cin, modulo 256. C is the carry out of bit 7 and H is the carry out of bit 3. V is set on signed overflow, N is bit 7 of the result and Z is set when the result is zero. The mask covers all five flags.
- R2: Code 2 (subtract) gives A-B modulo 256. C is set when B exceeds A as unsigned values. H is the borrow out of bit 3, V is signed overflow, N is bit 7 and Z marks a zero result. All five flags are updated.
- R3: Code 3 (subtract with carry) gives A-B-cin. C and H are the borrows, V is signed overflow and N is bit 7. Z becomes 0 when the result is nonzero and keeps its incoming value when the result is zero. All five flags are updated.
- R4: Codes 4 (AND), 5 (OR), 6 (exclusive OR) and 7 (A AND NOT B, the bit-clear form) update only Z, N and V, and they force V to 0.
- R5: Code 8 gives 0xFF minus A. It updates Z, C, N and V, with C forced to 1 and V forced to 0.
- R6: Code 9 gives 0x00 minus A and updates all five flags. C is set for any nonzero A, H is the borrow out of bit 3, and V is set only for A = 0x80.
- R7: Codes 10 (A+1) and 11 (A-1) update only Z, N and V. V is set for an increment of 0x7F and for a decrement of 0x80. C and H are never in their mask.
- R8: Code 12 shifts left and fills bit 0 with 0. Code 13 shifts right and fills bit 7 with 0. Code 16 shifts right and keeps bit 7. The bit shifted out goes to C. Z, C, N and V are updated, with V equal to N xor C after the operation.
- R9: Code 14 rotates left and code 15 rotates right, both through the carry-in. The carry-in enters the vacated end and the bit leaving the other end goes to C. Flags are as in R8.
- R10: Code 17 exchanges the two nibbles of A. Code 18 returns 0xFF. Both have an empty mask.
- R11: Flag vectors are packed as H in bit 4, V in bit 3, N in bit 2, Z in bit 1 and C in bit 0. Every flag outside the mask is output equal to its incoming value. Codes 19 to 31 return A unchanged with an empty mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Operand A (destination operand) |
| b_i | input | 8 | Operand B, register or immediate |
| cin_i | input | 1 | Carry-in for add, subtract and rotate with carry |
| flags_i | input | 5 | Current flags {H,V,N,Z,C} |
| res_o | output | 8 | Result |
| flags_o | output | 5 | New flags {H,V,N,Z,C}, unmasked bits passed through |
| upd_o | output | 5 | Mask of flags written by this operation |

## Verification
The subtract-with-carry case is where two functions meet in a single evaluation: the borrow chain that produces the result, C and H, and the retention of the incoming Z. The test drives equal operands with a zero carry-in, so the result is zero, and presents both values of the incoming Z. It then repeats the same operand pairs with a carry-in of 1, which gives a nonzero result and a borrow. Each outcome is compared with an integer model that computes the difference, the borrows and the retained Z directly from the operand values.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int FLAG_W = 5;
  localparam int FL_C   = 0;
  localparam int FL_Z   = 1;
  localparam int FL_N   = 2;
  localparam int FL_V   = 3;
  localparam int FL_H   = 4;

  typedef logic [FLAG_W-1:0] flag_vec_t;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_CBR  = 5'd7,
    OP_COM  = 5'd8,
    OP_NEG  = 5'd9,
    OP_INC  = 5'd10,
    OP_DEC  = 5'd11,
    OP_LSL  = 5'd12,
    OP_LSR  = 5'd13,
    OP_ROL  = 5'd14,
    OP_ROR  = 5'd15,
    OP_ASR  = 5'd16,
    OP_SWAP = 5'd17,
    OP_SER  = 5'd18
  } alu_op_e;

  typedef enum logic [2:0] {
    FAM_ARITH,
    FAM_STEP,
    FAM_LOGIC,
    FAM_COMPL,
    FAM_SHIFT,
    FAM_QUIET,
    FAM_NONE
  } alu_fam_e;

  localparam flag_vec_t MASK_ALL  = 5'b11111;
  localparam flag_vec_t MASK_ZNV  = 5'b01110;
  localparam flag_vec_t MASK_ZCNV = 5'b01111;
  localparam flag_vec_t MASK_NONE = 5'b00000;

  function automatic alu_fam_e op_family(input logic [4:0] code);
    alu_fam_e fam;
    case (code)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG:  fam = FAM_ARITH;
      OP_INC, OP_DEC:                          fam = FAM_STEP;
      OP_AND, OP_OR, OP_XOR, OP_CBR:           fam = FAM_LOGIC;
      OP_COM:                                  fam = FAM_COMPL;
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR:  fam = FAM_SHIFT;
      OP_SWAP, OP_SER:                         fam = FAM_QUIET;
      default:                                 fam = FAM_NONE;
    endcase
    return fam;
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  input  logic         sub,
  output logic [W-1:0] r,
  output logic         c_flag,
  output logic         h_flag,
  output logic         v_flag
);

  logic [W-1:0]   b_eff;
  logic           ci_eff;
  logic [W:0]     sum_full;
  logic [NIB:0]   sum_low;

  // Subtraction is addition of the inverted operand with an inverted borrow-in.
  always_comb begin
    b_eff    = sub ? ~b : b;
    ci_eff   = sub ? ~ci : ci;
    sum_full = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, ci_eff};
    sum_low  = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, ci_eff};
    r        = sum_full[W-1:0];
    // A carry out of an inverted-operand sum means "no borrow".
    c_flag   = sum_full[W] ^ sub;
    h_flag   = sum_low[NIB] ^ sub;
    v_flag   = (a[W-1] == b_eff[W-1]) && (sum_full[W-1] != a[W-1]);
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] r
);

  localparam int HALF = W / 2;

  always_comb begin
    case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_CBR:  r = a & ~b;
      OP_COM:  r = ~a;
      OP_SWAP: r = {a[HALF-1:0], a[W-1:HALF]};
      OP_SER:  r = '1;
      default: r = a;
    endcase
  end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic         ci,
  output logic [W-1:0] r,
  output logic         co
);

  always_comb begin
    case (op)
      OP_LSL: begin r = {a[W-2:0], 1'b0};    co = a[W-1]; end
      OP_LSR: begin r = {1'b0, a[W-1:1]};    co = a[0];   end
      OP_ROL: begin r = {a[W-2:0], ci};      co = a[W-1]; end
      OP_ROR: begin r = {ci, a[W-1:1]};      co = a[0];   end
      OP_ASR: begin r = {a[W-1], a[W-1:1]};  co = a[0];   end
      default: begin r = a;                  co = 1'b0;   end
    endcase
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [4:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic [4:0]   flags_i,
  output logic [W-1:0] res_o,
  output logic [4:0]   flags_o,
  output logic [4:0]   upd_o
);

  alu_op_e  op;
  alu_fam_e fam;

  logic [W-1:0] as_a, as_b, as_r;
  logic         as_ci, as_sub, as_c, as_h, as_v;
  logic [W-1:0] lg_r;
  logic [W-1:0] sh_r;
  logic         sh_c;

  logic [W-1:0] res;
  flag_vec_t    mask;
  logic         f_h, f_v, f_c, f_n, f_z;
  flag_vec_t    calc;

  assign op  = alu_op_e'(op_i);
  assign fam = op_family(op_i);

  // Operand steering for the shared adder.
  always_comb begin
    as_a   = a_i;
    as_b   = b_i;
    as_ci  = 1'b0;
    as_sub = 1'b0;
    case (op)
      OP_ADC: as_ci = cin_i;
      OP_SUB: as_sub = 1'b1;
      OP_SBC: begin as_sub = 1'b1; as_ci = cin_i; end
      OP_NEG: begin as_a = '0; as_b = a_i; as_sub = 1'b1; end
      OP_INC: as_b = W'(1);
      OP_DEC: begin as_b = W'(1); as_sub = 1'b1; end
      default: ;
    endcase
  end

  alu8_addsub #(.W(W), .NIB(NIB)) u_addsub (
    .a      (as_a),
    .b      (as_b),
    .ci     (as_ci),
    .sub    (as_sub),
    .r      (as_r),
    .c_flag (as_c),
    .h_flag (as_h),
    .v_flag (as_v)
  );

  alu8_logic #(.W(W)) u_logic (
    .op (op),
    .a  (a_i),
    .b  (b_i),
    .r  (lg_r)
  );

  alu8_shift #(.W(W)) u_shift (
    .op (op),
    .a  (a_i),
    .ci (cin_i),
    .r  (sh_r),
    .co (sh_c)
  );

  // Result selection, flag candidates and update mask by operation family.
  always_comb begin
    res  = a_i;
    mask = MASK_NONE;
    f_h  = 1'b0;
    f_v  = 1'b0;
    f_c  = 1'b0;
    case (fam)
      FAM_ARITH: begin
        res = as_r; mask = MASK_ALL;
        f_h = as_h; f_v = as_v; f_c = as_c;
      end
      FAM_STEP: begin
        res = as_r; mask = MASK_ZNV; f_v = as_v;
      end
      FAM_LOGIC: begin
        res = lg_r; mask = MASK_ZNV;
      end
      FAM_COMPL: begin
        res = lg_r; mask = MASK_ZCNV; f_c = 1'b1;
      end
      FAM_SHIFT: begin
        res = sh_r; mask = MASK_ZCNV;
        f_c = sh_c; f_v = sh_r[W-1] ^ sh_c;
      end
      FAM_QUIET: begin
        res = lg_r;
      end
      default: ;
    endcase
    f_n = res[W-1];
    // Subtract-with-carry may only clear Z, never set it.
    f_z = (res == '0) && ((op != OP_SBC) || flags_i[FL_Z]);
    calc = '0;
    calc[FL_H] = f_h;
    calc[FL_V] = f_v;
    calc[FL_N] = f_n;
    calc[FL_Z] = f_z;
    calc[FL_C] = f_c;
  end

  assign res_o   = res;
  assign upd_o   = mask;
  assign flags_o = (flags_i & ~mask) | (calc & mask);

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic [4:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         cin_i,
  input logic [4:0]   flags_i,
  input logic [W-1:0] res_o,
  input logic [4:0]   flags_o,
  input logic [4:0]   upd_o
);

  logic known;
  logic is_step, is_quiet, is_shift, is_logic, is_com, is_sbc;

  assign known    = !$isunknown({op_i, a_i, b_i, cin_i, flags_i});
  assign is_step  = (op_i == OP_INC) || (op_i == OP_DEC);
  assign is_quiet = (op_i == OP_SWAP) || (op_i == OP_SER) || (op_i > 5'd18);
  assign is_shift = (op_i >= OP_LSL) && (op_i <= OP_ASR);
  assign is_logic = (op_i >= OP_AND) && (op_i <= OP_CBR);
  assign is_com   = (op_i == OP_COM);
  assign is_sbc   = (op_i == OP_SBC);

  always_comb begin
    if (known) begin
      // R11
      keep_unmasked_chk: assert (((flags_o ^ flags_i) & ~upd_o) == 5'b0)
        else $error("unmasked flag changed");
      // R7
      step_no_carry_chk: assert (!is_step || (!upd_o[FL_C] && !upd_o[FL_H]))
        else $error("increment/decrement masks C or H");
      // R10
      quiet_mask_chk: assert (!is_quiet || (upd_o == 5'b0))
        else $error("quiet operation writes a flag");
      // R8
      shift_v_chk: assert (!is_shift || (flags_o[FL_V] == (flags_o[FL_N] ^ flags_o[FL_C])))
        else $error("shift V differs from N xor C");
      // R4
      logic_v_clear_chk: assert (!is_logic || (upd_o[FL_V] && !flags_o[FL_V]))
        else $error("logic operation left V set");
      // R5
      com_carry_chk: assert (!is_com || (upd_o[FL_C] && flags_o[FL_C]))
        else $error("complement did not set C");
      // R3
      sbc_z_sticky_chk: assert (!is_sbc || !flags_o[FL_Z] || flags_i[FL_Z])
        else $error("subtract with carry raised Z");
      // R1
      zero_flag_chk: assert (!upd_o[FL_Z] || is_sbc || (flags_o[FL_Z] == (res_o == '0)))
        else $error("Z does not reflect a zero result");
    end
  end

endmodule

bind alu8_core alu8_chk #(.W(W)) u_chk (
  .op_i    (op_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .cin_i   (cin_i),
  .flags_i (flags_i),
  .res_o   (res_o),
  .flags_o (flags_o),
  .upd_o   (upd_o)
);

// File: tb/sim_alu8_core.sv
`timescale 1ns/100ps
module sim_alu8_core;

  logic       clk;
  logic       rst_n;
  logic [4:0] op_i;
  logic [7:0] a_i, b_i;
  logic       cin_i;
  logic [4:0] flags_i;
  logic [7:0] res_o;
  logic [4:0] flags_o, upd_o;

  int checks;
  int failures;
  int cycles;
  bit done;

  alu8_core u0 (
    .op_i    (op_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .cin_i   (cin_i),
    .flags_i (flags_i),
    .res_o   (res_o),
    .flags_o (flags_o),
    .upd_o   (upd_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not complete, got %0d cycles expected < 150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic string req_tag(input int op);
    case (op)
      0, 1:                return "R1";
      2:                   return "R2";
      3:                   return "R3";
      4, 5, 6, 7:          return "R4";
      8:                   return "R5";
      9:                   return "R6";
      10, 11:              return "R7";
      12, 13, 16:          return "R8";
      14, 15:              return "R9";
      17, 18:              return "R10";
      default:             return "R11";
    endcase
  endfunction

  function automatic logic [7:0] b_pick(input int j);
    case (j)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h0F;  3: return 8'h10;
      4: return 8'h7F;  5: return 8'h80;  6: return 8'hFF;  7: return 8'h5A;
      8: return 8'hA5;  9: return 8'h3C;  10: return 8'hC3; default: return 8'hE1;
    endcase
  endfunction

  // Integer reference model; flag packing {H,V,N,Z,C}.
  function automatic void model(input int op, input int a, input int b, input int c,
                                input logic [4:0] fin, output logic [7:0] r,
                                output logic [4:0] f, output logic [4:0] m);
    int t, x, y, ci, sx, sy;
    logic hh, vv, cc, nn, zz;
    logic [4:0] calc;
    hh = 0; vv = 0; cc = 0; m = 5'b00000; t = a;
    case (op)
      0, 1: begin
        ci = (op == 1) ? c : 0;
        t  = a + b + ci; cc = (t > 255);
        hh = ((a % 16) + (b % 16) + ci) > 15;
        sx = (a > 127) ? a - 256 : a; sy = (b > 127) ? b - 256 : b;
        vv = ((sx + sy + ci) > 127) || ((sx + sy + ci) < -128);
        m  = 5'b11111;
      end
      2, 3, 9: begin
        x  = (op == 9) ? 0 : a; y = (op == 9) ? a : b; ci = (op == 3) ? c : 0;
        t  = x - y - ci; cc = (t < 0);
        hh = ((x % 16) - (y % 16) - ci) < 0;
        sx = (x > 127) ? x - 256 : x; sy = (y > 127) ? y - 256 : y;
        vv = ((sx - sy - ci) > 127) || ((sx - sy - ci) < -128);
        t  = t + 256;
        m  = 5'b11111;
      end
      4: begin t = a & b;          m = 5'b01110; end
      5: begin t = a | b;          m = 5'b01110; end
      6: begin t = a ^ b;          m = 5'b01110; end
      7: begin t = a & (255 - b);  m = 5'b01110; end
      8: begin t = 255 - a; cc = 1; m = 5'b01111; end
      10: begin t = a + 1;   vv = (a == 127); m = 5'b01110; end
      11: begin t = a + 255; vv = (a == 128); m = 5'b01110; end
      12: begin t = (a * 2) % 256;      cc = (a >= 128); m = 5'b01111; end
      13: begin t = a / 2;              cc = (a % 2 == 1); m = 5'b01111; end
      14: begin t = (a * 2) % 256 + c;  cc = (a >= 128); m = 5'b01111; end
      15: begin t = a / 2 + c * 128;    cc = (a % 2 == 1); m = 5'b01111; end
      16: begin t = a / 2 + ((a >= 128) ? 128 : 0); cc = (a % 2 == 1); m = 5'b01111; end
      17: t = (a % 16) * 16 + a / 16;
      18: t = 255;
      default: t = a;
    endcase
    t  = t % 256;
    r  = t[7:0];
    nn = r[7];
    zz = (r == 8'h00);
    if (op == 3) zz = zz && fin[1];
    if (op >= 12 && op <= 16) vv = nn ^ cc;
    calc = {hh, vv, nn, zz, cc};
    f = (fin & ~m) | (calc & m);
  endfunction

  task automatic check_now(input int op);
    logic [7:0] er;
    logic [4:0] ef, em;
    model(op, int'(a_i), int'(b_i), int'(cin_i), flags_i, er, ef, em);
    checks = checks + 1;
    if (res_o !== er || flags_o !== ef || upd_o !== em) begin
      failures = failures + 1;
      $display("FAIL %s op=%0d a=%h b=%h cin=%0d fin=%b: got res=%h flags=%b mask=%b expected res=%h flags=%b mask=%b",
               req_tag(op), op, a_i, b_i, cin_i, flags_i, res_o, flags_o, upd_o, er, ef, em);
    end
  endtask

  initial begin
    checks = 0; failures = 0; cycles = 0; done = 0;
    rst_n = 1'b0;
    op_i = 5'd0; a_i = 8'h00; b_i = 8'h00; cin_i = 1'b0; flags_i = 5'b00000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle inputs (add of zeros) give zero result with only Z set
    check_now(0);

    // Directed SBC corner: equal operands, zero result, both incoming Z values (R3)
    op_i = 5'd3; a_i = 8'h42; b_i = 8'h42; cin_i = 1'b0; flags_i = 5'b00010;
    #0.5 check_now(3); #0.5;
    flags_i = 5'b00000;
    #0.5 check_now(3); #0.5;
    cin_i = 1'b1; flags_i = 5'b00010;
    #0.5 check_now(3); #0.5;

    // Sweep: every code, every A, a spread of B, four carry/flag patterns
    for (int o = 0; o < 32; o++) begin
      for (int k = 0; k < 4; k++) begin
        for (int a = 0; a < 256; a++) begin
          for (int j = 0; j < 12; j++) begin
            op_i    = 5'(o);
            a_i     = 8'(a);
            b_i     = b_pick(j);
            cin_i   = (k == 1 || k == 3);
            flags_i = (k == 1 || k == 2) ? 5'b11111 : 5'b00000;
            #0.5 check_now(o);
            #0.5;
          end
        end
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule